// File: doc/BRIEF.md
# Interrupt Capture and Enable Controller

This unit collects twelve interrupt events from a bus controller and turns them into one level-sensitive interrupt line. Each source has three bits of state: a captured (status) bit, a mask bit that blocks capture, and an enable bit that lets a captured bit reach the output. Software changes the mask and enable vectors through separate set and clear writes in which a 1 acts and a 0 does nothing. It reads the status vector directly and clears bits in it by writing 1.

A set and a clear can reach a status bit in the same cycle. The data-overrun source lets the clear win. Every other source lets the set win. The receive-buffer-not-empty source is also driven by a level input. While the buffer holds data, clearing that bit does not stick: it is captured again.

Writes arrive as a strobe with a 3-bit selector and a data word. Reads are a combinational mux chosen by a 2-bit selector. The interrupt output is registered.

Top module: `irq_capture_unit`

## Requirements
- R1: After reset the status, mask and enable vectors read as zero and `irq_o` is 0.
- R2: A write with selector 0 clears every status bit whose data bit is 1. Status bits whose data bit is 0 are left unchanged.
- R3: For every source except bit 3, an event in the same cycle as a clear of that bit leaves the bit set.
- R4: For the data-overrun source (bit 3), a clear in the same cycle as an event leaves the bit cleared.
- R5: Selector 1 sets mask bits and selector 2 clears mask bits, each only where the data bit is 1. A source whose mask bit is 1 is never captured. Read selector 1 returns the mask vector.
- R6: Selector 3 sets enable bits and selector 4 clears enable bits, each only where the data bit is 1. Read selector 2 returns the enable vector.
- R7: `irq_o` is 1 exactly one cycle after a cycle in which some bit is both captured and enabled. It is 0 otherwise, so a captured but disabled source does not raise it.
- R8: While `rbne_lvl_i` is 1 and bit 10 is unmasked, bit 10 is captured, even in a cycle where software clears it. Once the level is 0, a clear of bit 10 sticks.
- R9: A write with selector 5, 6 or 7 changes no state.
- R10: Read selector 0 returns the status vector and read selector 3 returns zero.
- R11: Bit order of sources, from bit 0 up: frame received, frame transmitted, error warning, data overrun, error passive/bus-off, arbitration lost, bus error, logging finished, receive buffer full, bit-rate shifted, receive buffer not empty, TX buffer hardware command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 3 | Write target: 0 status clear, 1 mask set, 2 mask clear, 3 enable set, 4 enable clear |
| wr_data_i | input | 12 | Write data, one bit per source |
| rd_sel_i | input | 2 | Read target: 0 status, 1 mask, 2 enable, 3 zero |
| rd_data_o | output | 12 | Read data |
| evt_i | input | 12 | Per-source event pulses |
| rbne_lvl_i | input | 1 | Receive buffer currently holds data |
| irq_o | output | 1 | Registered interrupt level |

## Verification
The hardest situations to reach from the ports are a software clear landing in exactly the cycle of an event on the same bit, and a clear of bit 10 while the buffer level is still high. Each priority rule only shows up in those cycles. Directed sequences line up the event or level with the clear write on purpose. Long random runs then mix events, level changes and every selector, including the unused ones, so that these collisions also happen many times with random masks and enables.

// File: rtl/irq_cap_pkg.sv
package irq_cap_pkg;

    typedef enum logic [2:0] {
        WSEL_STAT_CLR = 3'd0,
        WSEL_MASK_SET = 3'd1,
        WSEL_MASK_CLR = 3'd2,
        WSEL_ENA_SET  = 3'd3,
        WSEL_ENA_CLR  = 3'd4
    } wsel_e;

    typedef enum logic [1:0] {
        RSEL_STAT = 2'd0,
        RSEL_MASK = 2'd1,
        RSEL_ENA  = 2'd2,
        RSEL_NONE = 2'd3
    } rsel_e;

    // Source bit positions (R11)
    localparam int SRC_RX_DONE   = 0;
    localparam int SRC_TX_DONE   = 1;
    localparam int SRC_ERR_WARN  = 2;
    localparam int SRC_OVERRUN   = 3;
    localparam int SRC_ERR_PASS  = 4;
    localparam int SRC_ARB_LOST  = 5;
    localparam int SRC_BUS_ERR   = 6;
    localparam int SRC_LOG_DONE  = 7;
    localparam int SRC_RX_FULL   = 8;
    localparam int SRC_RATE_SHFT = 9;
    localparam int SRC_RX_NEMPTY = 10;
    localparam int SRC_TXB_HWCMD = 11;
    localparam int NUM_SOURCES   = 12;

endpackage

// File: rtl/irq_vec_reg.sv
module irq_vec_reg #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_we,
    input  logic         clr_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] vec;
    } vreg_t;

    vreg_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (set_we) s_d.vec = s_q.vec | wdata;
        if (clr_we) s_d.vec = s_q.vec & ~wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign q = s_q.vec;

    for (genvar i = 0; i < W; i++) begin : g_chk
        AST_VEC_SET: assert property (@(posedge clk) disable iff (!rst_n)
            (set_we && wdata[i]) |=> q[i]);                 // R5
        AST_VEC_CLR: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_we && wdata[i]) |=> !q[i]);                // R6
        AST_VEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (!(set_we && wdata[i]) && !(clr_we && wdata[i])) |=> $stable(q[i])); // R9
    end

endmodule

// File: rtl/irq_status.sv
module irq_status #(
    parameter int W         = 12,
    parameter int CLR_WINS  = 3,
    parameter int LEVEL_IDX = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt,
    input  logic         level,
    input  logic [W-1:0] mask,
    input  logic         clr_we,
    input  logic [W-1:0] clr_data,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] stat;
    } sreg_t;

    sreg_t        s_d, s_q;
    logic [W-1:0] cond;
    logic [W-1:0] setv;
    logic [W-1:0] clrv;
    logic [W-1:0] nxt;

    always_comb begin
        cond            = evt;
        cond[LEVEL_IDX] = evt[LEVEL_IDX] | level;
        setv            = cond & ~mask;
        clrv            = clr_we ? clr_data : '0;
    end

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (i == CLR_WINS) begin : g_clr_first
            assign nxt[i] = (s_q.stat[i] | setv[i]) & ~clrv[i];
        end else begin : g_set_first
            assign nxt[i] = (s_q.stat[i] & ~clrv[i]) | setv[i];
        end
    end

    always_comb begin
        s_d      = s_q;
        s_d.stat = nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign q = s_q.stat;

    for (genvar i = 0; i < W; i++) begin : g_chk
        AST_MASKED_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
            (mask[i] && !q[i]) |=> !q[i]);                  // R5
        AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
            (!cond[i] && !q[i]) |=> !q[i]);                 // R2
        if (i == CLR_WINS) begin : g_a_clr
            AST_CLEAR_BEATS_SET: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_we && clr_data[i]) |=> !q[i]);         // R4
        end else begin : g_a_set
            AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
                (cond[i] && !mask[i]) |=> q[i]);            // R3
        end
    end

    AST_LEVEL_REARM: assert property (@(posedge clk) disable iff (!rst_n)
        (level && !mask[LEVEL_IDX]) |=> q[LEVEL_IDX]);      // R8

endmodule

// File: rtl/irq_capture_unit.sv
module irq_capture_unit
    import irq_cap_pkg::*;
#(
    parameter int NSRC       = NUM_SOURCES,
    parameter int OVR_BIT    = SRC_OVERRUN,
    parameter int RBNE_BIT   = SRC_RX_NEMPTY
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en_i,
    input  logic [2:0]      wr_sel_i,
    input  logic [NSRC-1:0] wr_data_i,
    input  logic [1:0]      rd_sel_i,
    output logic [NSRC-1:0] rd_data_o,
    input  logic [NSRC-1:0] evt_i,
    input  logic            rbne_lvl_i,
    output logic            irq_o
);
    typedef struct packed {
        logic irq;
    } oreg_t;

    oreg_t s_d, s_q;

    logic            we_stat_clr, we_mask_set, we_mask_clr, we_ena_set, we_ena_clr;
    logic [NSRC-1:0] stat_q, mask_q, ena_q;

    always_comb begin
        we_stat_clr = wr_en_i && (wr_sel_i == WSEL_STAT_CLR);
        we_mask_set = wr_en_i && (wr_sel_i == WSEL_MASK_SET);
        we_mask_clr = wr_en_i && (wr_sel_i == WSEL_MASK_CLR);
        we_ena_set  = wr_en_i && (wr_sel_i == WSEL_ENA_SET);
        we_ena_clr  = wr_en_i && (wr_sel_i == WSEL_ENA_CLR);
    end

    irq_vec_reg #(.W(NSRC)) u_mask (
        .clk(clk), .rst_n(rst_n), .set_we(we_mask_set), .clr_we(we_mask_clr),
        .wdata(wr_data_i), .q(mask_q)
    );

    irq_vec_reg #(.W(NSRC)) u_ena (
        .clk(clk), .rst_n(rst_n), .set_we(we_ena_set), .clr_we(we_ena_clr),
        .wdata(wr_data_i), .q(ena_q)
    );

    irq_status #(.W(NSRC), .CLR_WINS(OVR_BIT), .LEVEL_IDX(RBNE_BIT)) u_stat (
        .clk(clk), .rst_n(rst_n), .evt(evt_i), .level(rbne_lvl_i), .mask(mask_q),
        .clr_we(we_stat_clr), .clr_data(wr_data_i), .q(stat_q)
    );

    always_comb begin
        s_d     = s_q;
        s_d.irq = |(stat_q & ena_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign irq_o = s_q.irq;

    always_comb begin
        unique case (rd_sel_i)
            RSEL_STAT: rd_data_o = stat_q;
            RSEL_MASK: rd_data_o = mask_q;
            RSEL_ENA:  rd_data_o = ena_q;
            default:   rd_data_o = '0;
        endcase
    end

    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (ena_q == '0) |=> !irq_o);                          // R7
    AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q == '0) |=> !irq_o);                         // R7

endmodule

// File: tb/irq_capture_unit_tb.sv
module irq_capture_unit_tb;
    localparam int N = 12;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [2:0]   wr_sel = '0;
    logic [N-1:0] wr_data = '0;
    logic [1:0]   rd_sel = '0;
    logic [N-1:0] rd_data;
    logic [N-1:0] evt = '0;
    logic         rbne = 1'b0;
    logic         irq;

    int checks = 0;
    int fails  = 0;

    logic [N-1:0] m_stat = '0, m_mask = '0, m_ena = '0;
    logic         m_irq = 1'b0;

    always #10 clk = ~clk;

    irq_capture_unit u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
        .wr_data_i(wr_data), .rd_sel_i(rd_sel), .rd_data_o(rd_data),
        .evt_i(evt), .rbne_lvl_i(rbne), .irq_o(irq)
    );

    function automatic logic [N-1:0] exp_stat(
        input logic [N-1:0] st, input logic [N-1:0] mk, input logic [N-1:0] ev,
        input logic lv, input logic we, input logic [2:0] sel, input logic [N-1:0] d);
        logic [N-1:0] c, s, k, r;
        c = ev;
        c[10] = c[10] | lv;
        s = c & ~mk;
        k = (we && sel == 3'd0) ? d : '0;
        r = (st & ~k) | s;
        r[3] = (st[3] | s[3]) & ~k[3];
        return r;
    endfunction

    function automatic logic [N-1:0] exp_vec(
        input logic [N-1:0] v, input logic we, input logic [2:0] sel,
        input logic [2:0] set_code, input logic [N-1:0] d);
        if (we && sel == set_code)        return v | d;
        if (we && sel == set_code + 3'd1) return v & ~d;
        return v;
    endfunction

    task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string st_tag);
        rd_sel = 2'd0; #1; check(st_tag, rd_data, m_stat);
        rd_sel = 2'd1; #1; check("R5 mask readback", rd_data, m_mask);
        rd_sel = 2'd2; #1; check("R6 enable readback", rd_data, m_ena);
        rd_sel = 2'd3; #1; check("R10 unused read", rd_data, '0);
        check("R7 irq", {{(N-1){1'b0}}, irq}, {{(N-1){1'b0}}, m_irq});
    endtask

    // inputs must already be driven; advances one edge and checks
    task automatic step(input string st_tag);
        logic [N-1:0] ns, nm, ne;
        logic ni;
        ns = exp_stat(m_stat, m_mask, evt, rbne, wr_en, wr_sel, wr_data);
        nm = exp_vec(m_mask, wr_en, wr_sel, 3'd1, wr_data);
        ne = exp_vec(m_ena,  wr_en, wr_sel, 3'd3, wr_data);
        ni = |(m_stat & m_ena);
        @(posedge clk);
        #2;
        m_stat = ns; m_mask = nm; m_ena = ne; m_irq = ni;
        wr_en = 1'b0; evt = '0;
        check_all(st_tag);
    endtask

    task automatic wr(input logic [2:0] s, input logic [N-1:0] d);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
    endtask

    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #5;
        check_all("R1 reset status");
        rst_n = 1'b1;
        @(negedge clk);

        // enable everything
        wr(3'd3, '1); step("R6 enable all");
        // R2: capture bits 0,1, clear only bit 0
        evt = 12'h003; step("R2 capture");
        step("R7 irq follows");
        wr(3'd0, 12'h001); step("R2 clear one");
        wr(3'd0, 12'h000); step("R2 zero write");
        // R3: event and clear on same bit 5
        evt = 12'h020; wr(3'd0, 12'h020); step("R3 set wins");
        // R4: overrun bit 3
        evt = 12'h008; step("R4 prep");
        evt = 12'h008; wr(3'd0, 12'h008); step("R4 clear wins");
        // R8: level re-arm on bit 10
        rbne = 1'b1; step("R8 level capture");
        wr(3'd0, 12'h400); step("R8 rearm");
        rbne = 1'b0; wr(3'd0, 12'h400); step("R8 clear sticks");
        // R5: mask bit 6, event ignored
        wr(3'd1, 12'h040); step("R5 mask set");
        evt = 12'h040; step("R5 masked no capture");
        wr(3'd2, 12'h040); step("R5 mask clear");
        // R9: unused selectors
        wr(3'd5, '1); step("R9 sel5");
        wr(3'd7, '1); step("R9 sel7");
        // R7: disable all, captured bits stay but irq drops
        wr(3'd4, '1); step("R7 disable");
        step("R7 captured but disabled");
        wr(3'd0, '1); step("R2 clear all");

        for (int i = 0; i < 4000; i++) begin
            evt  = N'($urandom) & N'($urandom);
            rbne = ($urandom % 4) == 0;
            if (($urandom % 3) != 0) wr(3'($urandom), N'($urandom));
            step("R2 R3 R4 R8 random status");
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h1234_5678));
    end

endmodule